// File: doc/BRIEF.md
# Keyed watchdog with timeout prescaler

This block is a watchdog timer for a processor subsystem. It counts machine-cycle enables and, if software fails to service it in time, drives a reset pulse of fixed length. Software arms the watchdog and later services it by writing a two-byte key to its key register: first 1Eh, then E1h. Once armed, it cannot be switched off by any write. Only the external reset, or the watchdog's own reset pulse, returns it to the disarmed state.

A 3-bit prescale field stretches the timeout. With field value n, the timeout covers 2^(BASE_W+n)−1 enables. For the default BASE_W of 14, this runs from a 14-bit span up to a 21-bit span. The length of the reset pulse is counted in clocks and depends on the clock-mode flag that is sampled when the timeout occurs.

Both registers sit on a plain write port with an enable, an address and a data byte. The port takes a write in every cycle and never stalls, so it carries no back-pressure. The machine-cycle enable, the speed flag and the reset output are plain control pins.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, `wdt_rst_o` is low and the watchdog is disarmed. Any number of machine-cycle enables without a key produces no pulse.
- R2: A write of 1Eh to address KEY_ADDR (default 0), followed later by a write of E1h to the same address, arms the watchdog with its count at zero.
- R3: Once armed, no sequence of writes disarms the watchdog. Only `rst_n` low, or the watchdog's own pulse, clears it. `rst_n` also clears the count and the prescale field.
- R4: While armed, the count advances by one for each clock in which `cyc_en` is high. Clocks with `cyc_en` low leave it unchanged.
- R5: The prescale field n is bits [2:0] of a write to address PRE_ADDR (default 1) and resets to 0. `wdt_rst_o` rises in the clock after the enable that brings the count since arming or the last refresh to 2^(BASE_W+n)−1.
- R6: The pulse lasts FAST_LEN (96) clocks if `fast_mode` is 1, or SLOW_LEN (192) clocks if it is 0. The value used is the one in the cycle of the timeout enable.
- R7: While armed, a completed 1Eh/E1h key restarts the count from zero.
- R8: After 1Eh, any key-register value other than E1h abandons the sequence without refreshing. A repeated 1Eh keeps the sequence waiting for E1h. Writes to other addresses do not disturb the sequence, and E1h without a preceding 1Eh does nothing.
- R9: When a key completes in the same cycle as the timeout enable, the refresh wins: no pulse occurs and counting restarts from zero.
- R10: The watchdog's own pulse clears the armed state, the count and the key sequence. All writes made during the pulse are ignored, and the watchdog stays disarmed after the pulse until a new key arrives.
- R11: The prescale field survives the watchdog's own pulse. It may be rewritten while armed and takes effect on the next enable, so lowering it below the current count causes a timeout at that next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | 8 | Write data |
| cyc_en | input | 1 | Machine-cycle enable, one clock wide |
| fast_mode | input | 1 | 1 = double-speed clock mode (short pulse) |
| wdt_rst_o | output | 1 | Watchdog reset pulse, active high |

## Verification
The interesting collision is a key that completes in the same clock as the enable that would time the watchdog out. The bench provokes it by writing 1Eh early, running enables up to one short of the limit, and then issuing the final enable together with the E1h write. It judges the outcome by observing no pulse on the next clock and a full, fresh timeout interval afterwards. A second overlap, key and prescale writes landing during the pulse itself, is judged by the pulse ending normally and the watchdog staying silent afterwards. A cycle-by-cycle reference model compares the output on every clock.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_HALF = 1'b1
  } key_st_e;

  localparam logic [7:0] KEY_FIRST  = 8'h1E;
  localparam logic [7:0] KEY_SECOND = 8'hE1;
endpackage

// File: rtl/kwd_key_seq.sv
module kwd_key_seq
  import keyed_wdog_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] KEY_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              refresh_o
);
  key_st_e st_q;
  logic    key_hit;

  assign key_hit   = wr_en && (wr_addr == KEY_ADDR) && !hold;
  assign refresh_o = key_hit && (st_q == SEQ_HALF) && (wr_data == KEY_SECOND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       st_q <= SEQ_IDLE;
    else if (hold)    st_q <= SEQ_IDLE;
    else if (key_hit) st_q <= (wr_data == KEY_FIRST) ? SEQ_HALF : SEQ_IDLE;
  end

  AST_SEQ_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_o |=> (st_q == SEQ_IDLE)); // R8
  AST_HOLD_CLEARS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (st_q == SEQ_IDLE)); // R10
endmodule

// File: rtl/kwd_timebase.sv
module kwd_timebase #(
  parameter int BASE_W = 14,
  parameter int PRE_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             refresh,
  input  logic             busy,
  input  logic [PRE_W-1:0] pre,
  output logic             armed_o,
  output logic             timeout_o
);
  localparam int NSEL  = 1 << PRE_W;
  localparam int CNT_W = BASE_W + NSEL - 1;

  logic [CNT_W-1:0] lim_tab [NSEL];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic [CNT_W:0]   cnt_inc;
  logic             armed_q;

  for (genvar i = 0; i < NSEL; i++) begin : g_lim
    localparam logic [CNT_W:0] LIMW =
      ((CNT_W+1)'(1) << (BASE_W + i)) - (CNT_W+1)'(1);
    assign lim_tab[i] = LIMW[CNT_W-1:0];
  end

  assign limit     = lim_tab[pre];
  assign cnt_inc   = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign timeout_o = armed_q && cyc_en && !refresh && !busy &&
                     (cnt_inc >= {1'b0, limit});
  assign armed_o   = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (busy || timeout_o) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (refresh) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (armed_q && cyc_en) begin
      cnt_q <= cnt_inc[CNT_W-1:0];
    end
  end

  AST_ARMED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !timeout_o && !busy) |=> armed_q); // R3
  AST_REFRESH_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh && !busy) |=> (armed_q && cnt_q == '0)); // R7
  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !cyc_en && !refresh && !busy) |=> $stable(cnt_q)); // R4
  AST_DISARMED_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!armed_q && cnt_q == '0)); // R10
endmodule

// File: rtl/kwd_pulse.sv
module kwd_pulse #(
  parameter int FAST_LEN = 96,
  parameter int SLOW_LEN = 192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic fast_mode,
  output logic active_o
);
  localparam int MAXL  = (FAST_LEN > SLOW_LEN) ? FAST_LEN : SLOW_LEN;
  localparam int LEN_W = $clog2(MAXL + 1);

  logic [LEN_W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             rem_q <= '0;
    else if (fire)          rem_q <= fast_mode ? LEN_W'(FAST_LEN) : LEN_W'(SLOW_LEN);
    else if (rem_q != '0)   rem_q <= rem_q - LEN_W'(1);
  end

  assign active_o = (rem_q != '0);

  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> active_o); // R6
  AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> !fire); // R10
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import keyed_wdog_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] KEY_ADDR = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] PRE_ADDR = ADDR_W'(1),
  parameter int BASE_W   = 14,
  parameter int PRE_W    = 3,
  parameter int FAST_LEN = 96,
  parameter int SLOW_LEN = 192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              cyc_en,
  input  logic              fast_mode,
  output logic              wdt_rst_o
);
  logic             busy;
  logic             refresh;
  logic             armed;
  logic             timeout;
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pre_q <= '0;
    else if (wr_en && (wr_addr == PRE_ADDR) && !busy)
      pre_q <= wr_data[PRE_W-1:0];
  end

  kwd_key_seq #(.ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR)) u_key (
    .clk(clk), .rst_n(rst_n), .hold(busy),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .refresh_o(refresh)
  );

  kwd_timebase #(.BASE_W(BASE_W), .PRE_W(PRE_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .refresh(refresh),
    .busy(busy), .pre(pre_q), .armed_o(armed), .timeout_o(timeout)
  );

  kwd_pulse #(.FAST_LEN(FAST_LEN), .SLOW_LEN(SLOW_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(timeout), .fast_mode(fast_mode),
    .active_o(busy)
  );

  assign wdt_rst_o = busy;

  AST_ARM_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(wr_en && wr_addr == KEY_ADDR && wr_data == KEY_SECOND)); // R2
  AST_PULSE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_o) |-> $past(armed)); // R5
  AST_PRE_FROZEN_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |=> $stable(pre_q)); // R10
  AST_PULSE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |-> !armed); // R10
endmodule

// File: tb/keyed_wdog_bench.sv
module keyed_wdog_bench;
  localparam int B = 6;
  localparam logic [3:0] KA = 4'd0;
  localparam logic [3:0] PA = 4'd1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic cyc_en = 1'b0;
  logic fast_mode = 1'b1;
  logic wdt_rst_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string cur_req = "R1";

  int m_armed, m_cnt, m_half, m_left, m_pre, m_lim;
  bit m_ref, m_tmo;

  keyed_wdog #(.ADDR_W(4), .KEY_ADDR(KA), .PRE_ADDR(PA), .BASE_W(B)) u_keyed_wdog (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cyc_en(cyc_en), .fast_mode(fast_mode), .wdt_rst_o(wdt_rst_o)
  );

  always #10 clk = ~clk;

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_armed = 0; m_cnt = 0; m_half = 0; m_left = 0; m_pre = 0;
    end else if (m_left > 0) begin
      m_left = m_left - 1; m_armed = 0; m_cnt = 0; m_half = 0;
    end else begin
      m_lim = (1 << (B + m_pre)) - 1;
      m_ref = 1'b0;
      if (wr_en && wr_addr == KA) begin
        if (m_half != 0 && wr_data == 8'hE1) m_ref = 1'b1;
        m_half = (wr_data == 8'h1E) ? 1 : 0;
      end
      m_tmo = !m_ref && (m_armed != 0) && cyc_en && (m_cnt + 1 >= m_lim);
      if (wr_en && wr_addr == PA) m_pre = int'(wr_data) & 7;
      if (m_ref) begin
        m_armed = 1; m_cnt = 0;
      end else if (m_tmo) begin
        m_left = fast_mode ? 96 : 192; m_armed = 0; m_cnt = 0;
      end else if (m_armed != 0 && cyc_en) begin
        m_cnt = m_cnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (wdt_rst_o !== (m_left > 0)) begin
      fails++;
      $display("FAIL %s cycle-compare: actual=%0b expected=%0b", cur_req, wdt_rst_o, m_left > 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000) begin
      fails++;
      $display("FAIL watchdog-timer of bench expired: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic tick(input bit en, input bit w, input logic [3:0] a, input logic [7:0] d);
    cyc_en = en; wr_en = w; wr_addr = a; wr_data = d;
    @(negedge clk);
    cyc_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic idle(input int n, input bit en);
    for (int i = 0; i < n; i++) tick(en, 1'b0, KA, 8'h00);
  endtask

  task automatic arm();
    tick(1'b0, 1'b1, KA, 8'h1E);
    tick(1'b0, 1'b1, KA, 8'hE1);
  endtask

  task automatic set_pre(input int v);
    tick(1'b0, 1'b1, PA, 8'(v));
  endtask

  task automatic to_pulse(input int max, output int n);
    n = 0;
    while (!wdt_rst_o && n < max) begin
      tick(1'b1, 1'b0, KA, 8'h00);
      n++;
    end
  endtask

  task automatic pulse_len(output int n);
    n = 0;
    while (wdt_rst_o && n < 1000) begin
      tick(1'b0, 1'b0, KA, 8'h00);
      n++;
    end
  endtask

  initial begin
    int n;
    int hit;
    repeat (3) @(negedge clk);
    chk(wdt_rst_o == 1'b0, "R1 reset level", int'(wdt_rst_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: no key, no pulse
    cur_req = "R1";
    idle(200, 1'b1);
    chk(wdt_rst_o == 1'b0, "R1 unkeyed enables", int'(wdt_rst_o), 0);

    // R2 / R5 / R6 fast pulse
    cur_req = "R2";
    arm();
    to_pulse(5000, n);
    chk(n == 63, "R2 R5 enables to timeout", n, 63);
    pulse_len(n);
    chk(n == 96, "R6 fast pulse length", n, 96);
    // R10: disarmed afterwards
    cur_req = "R10";
    hit = 0;
    for (int i = 0; i < 200; i++) begin
      tick(1'b1, 1'b0, KA, 8'h00);
      if (wdt_rst_o) hit = 1;
    end
    chk(hit == 0, "R10 disarmed after pulse", hit, 0);

    // R6 slow pulse
    cur_req = "R6";
    fast_mode = 1'b0;
    arm();
    to_pulse(5000, n);
    chk(n == 63, "R6 slow timeout", n, 63);
    pulse_len(n);
    chk(n == 192, "R6 slow pulse length", n, 192);
    fast_mode = 1'b1;

    // R7 refresh
    cur_req = "R7";
    arm();
    idle(50, 1'b1);
    arm();
    idle(50, 1'b1);
    chk(wdt_rst_o == 1'b0, "R7 no pulse after refresh", int'(wdt_rst_o), 0);
    to_pulse(5000, n);
    chk(n == 13, "R7 restart from zero", n, 13);
    pulse_len(n);

    // R8 broken sequences
    cur_req = "R8";
    arm();
    idle(50, 1'b1);
    tick(1'b0, 1'b1, KA, 8'h1E);
    tick(1'b0, 1'b1, KA, 8'h55);
    tick(1'b0, 1'b1, KA, 8'hE1);
    to_pulse(5000, n);
    chk(n == 13, "R8 abandoned key no refresh", n, 13);
    pulse_len(n);
    arm();
    idle(30, 1'b1);
    tick(1'b0, 1'b1, KA, 8'h1E);
    tick(1'b0, 1'b1, KA, 8'h1E);
    tick(1'b0, 1'b1, PA, 8'h00);
    tick(1'b0, 1'b1, KA, 8'hE1);
    to_pulse(5000, n);
    chk(n == 63, "R8 repeated 1E and foreign write keep key", n, 63);
    pulse_len(n);

    // R3 no disarm by writes
    cur_req = "R3";
    arm();
    tick(1'b1, 1'b1, KA, 8'h00);
    tick(1'b1, 1'b1, KA, 8'hE1);
    tick(1'b1, 1'b1, KA, 8'h1E);
    tick(1'b1, 1'b1, KA, 8'h55);
    to_pulse(5000, n);
    chk(n == 59, "R3 still armed after writes", n, 59);
    pulse_len(n);

    // R4 sparse enables
    cur_req = "R4";
    arm();
    hit = 0;
    for (int i = 0; i < 62; i++) begin
      tick(1'b1, 1'b0, KA, 8'h00);
      tick(1'b0, 1'b0, KA, 8'h00);
      tick(1'b0, 1'b0, KA, 8'h00);
      if (wdt_rst_o) hit = 1;
    end
    chk(hit == 0, "R4 idle clocks do not count", hit, 0);
    tick(1'b1, 1'b0, KA, 8'h00);
    chk(wdt_rst_o == 1'b1, "R4 63rd enable times out", int'(wdt_rst_o), 1);
    pulse_len(n);

    // R9 collision: refresh beats timeout
    cur_req = "R9";
    arm();
    tick(1'b0, 1'b1, KA, 8'h1E);
    idle(62, 1'b1);
    tick(1'b1, 1'b1, KA, 8'hE1);
    chk(wdt_rst_o == 1'b0, "R9 refresh wins over timeout", int'(wdt_rst_o), 0);
    to_pulse(5000, n);
    chk(n == 63, "R9 full interval after collision", n, 63);

    // R10 writes during the pulse are ignored
    cur_req = "R10";
    tick(1'b0, 1'b1, KA, 8'h1E);
    tick(1'b0, 1'b1, KA, 8'hE1);
    tick(1'b0, 1'b1, PA, 8'h03);
    pulse_len(n);
    hit = 0;
    for (int i = 0; i < 300; i++) begin
      tick(1'b1, 1'b0, KA, 8'h00);
      if (wdt_rst_o) hit = 1;
    end
    chk(hit == 0, "R10 key during pulse ignored", hit, 0);
    arm();
    to_pulse(5000, n);
    chk(n == 63, "R10 prescale write during pulse ignored", n, 63);
    pulse_len(n);

    // R5 every prescale value
    cur_req = "R5";
    for (int p = 0; p < 8; p++) begin
      set_pre(p);
      arm();
      to_pulse(20000, n);
      chk(n == (1 << (B + p)) - 1, "R5 prescale timeout", n, (1 << (B + p)) - 1);
      pulse_len(n);
    end

    // R11 retention and live change
    cur_req = "R11";
    set_pre(1);
    arm();
    to_pulse(5000, n);
    pulse_len(n);
    arm();
    to_pulse(5000, n);
    chk(n == 127, "R11 prescale kept across pulse", n, 127);
    pulse_len(n);
    set_pre(2);
    arm();
    idle(100, 1'b1);
    set_pre(0);
    tick(1'b1, 1'b0, KA, 8'h00);
    chk(wdt_rst_o == 1'b1, "R11 lowered prescale times out at once", int'(wdt_rst_o), 1);
    pulse_len(n);

    // R3 external reset clears
    cur_req = "R3";
    set_pre(1);
    arm();
    idle(40, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    hit = 0;
    for (int i = 0; i < 300; i++) begin
      tick(1'b1, 1'b0, KA, 8'h00);
      if (wdt_rst_o) hit = 1;
    end
    chk(hit == 0, "R3 external reset disarms", hit, 0);
    arm();
    to_pulse(5000, n);
    chk(n == 63, "R3 reset clears prescale", n, 63);
    pulse_len(n);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule